// File: doc/BRIEF.md
# Dual-Channel PWM Generator with Complementary Deadtime

This block holds two independent pulse-width generators and a routing stage that drives a high-side pin and a low-side pin. Each generator has its own run bit, its own selectable clock prescaler (divide by 4 or by 12) and a 16-bit counter that counts from zero up to a programmed period and then wraps. Its output is high while the counter is below a programmed duty value. The host sets every control bit, period, duty and the deadtime count through a plain byte-wide write strobe.

The routing stage has two modes. In independent mode the high pin carries generator 0 and the low pin carries generator 1, and the deadtime logic is held idle. In complementary mode generator 0 drives both pins in opposite phase, as a half-bridge gate driver needs. Every rising edge on either pin is then held back by a programmable number of system clocks, so both pins sit low around each switch-over. A deadtime of zero gives plain complementary outputs.

Top module: `dual_pwm_deadtime`

## Requirements
- R1: After reset both pins are low, both run bits are clear, both prescalers select divide-by-4 and the pin pair is in independent mode.
- R2: While running, a generator's counter advances once every 4 system clocks when its prescale bit is 0 and once every 12 when it is 1. The first advance comes that many clocks after the write that set the run bit.
- R3: A running generator counts 0,1,...,period and then returns to 0. Its output is high exactly while the count is below duty, so duty 0 keeps it low and a duty above the period keeps it high.
- R4: Clearing a run bit drives that generator's output low from the capturing edge onward and returns its counter to 0. Setting the bit again restarts the waveform from count 0.
- R5: A duty or period written while a generator runs takes effect only when its counter next wraps to 0. Until then the frame in progress keeps the old value.
- R6: With the mode bit at 0, pwm_hi equals generator 0 and pwm_lo equals generator 1, with no deadtime applied.
- R7: With the mode bit at 1, pwm_hi follows generator 0 and pwm_lo follows its inverse. A deadtime of 0 makes the two pins exact complements.
- R8: With the mode bit at 1 and deadtime d, each pin goes high only after its source has been high for d+1 consecutive clocks (a rise delayed by d clocks). A source pulse shorter than that never reaches the pin. Falling edges are not delayed.
- R9: With the mode bit at 1, pwm_hi and pwm_lo are never high in the same clock cycle.
- R10: Register writes take effect at the clock edge that samples wr_en high. Address 0 is control, with run0 in bit 0, run1 in bit 1, prescale0 in bit 2, prescale1 in bit 3 and mode in bit 4. Address 1 is the deadtime count. For channel c, period low byte, period high byte, duty low byte and duty high byte sit at addresses 2+4c to 5+4c.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_hi | output | 1 | High-side output pin |
| pwm_lo | output | 1 | Low-side output pin |

## Verification
A write is captured at the rising edge that samples wr_en, and a generator's output reflects a run-bit change right after that same edge, because the compare output is combinational from the run register and counter. The counter first moves 4 or 12 clocks later, and in complementary mode a pin rises d clocks after its source. The bench samples 2 ns after every rising edge. It indexes a cycle-count model from the capturing edge of the last run-bit write, so each expected value refers to the same edge the hardware used. Duty changes in flight are credited to the frame that follows the write's sample.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  localparam int NCH          = 2;
  localparam int A_CTRL       = 0;
  localparam int A_DEAD       = 1;
  localparam int A_GEN_BASE   = 2;
  localparam int A_GEN_STRIDE = 4;
  localparam int OFF_PER_LO   = 0;
  localparam int OFF_PER_HI   = 1;
  localparam int OFF_DUTY_LO  = 2;
  localparam int OFF_DUTY_HI  = 3;

  // control byte, LSB first: run0, run1, pre0, pre1, mode
  typedef struct packed {
    logic       comp;
    logic [1:0] pre;
    logic [1:0] run;
  } dpwm_ctrl_t;

  function automatic int gen_addr(input int ch, input int off);
    return A_GEN_BASE + A_GEN_STRIDE * ch + off;
  endfunction

  // last prescaler phase before a counter step
  function automatic int pre_last(input logic sel, input int div_lo, input int div_hi);
    return sel ? div_hi - 1 : div_lo - 1;
  endfunction

endpackage

// File: rtl/dpwm_regs.sv
module dpwm_regs
  import dpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DT_W   = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output dpwm_ctrl_t                    ctrl_q,
  output logic [DT_W-1:0]               dead_q,
  output logic [NCH-1:0][CNT_W-1:0]     per_q,
  output logic [NCH-1:0][CNT_W-1:0]     duty_q
);

  localparam int HI_W   = CNT_W - DATA_W;
  localparam int CTRL_W = $bits(dpwm_ctrl_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dead_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_CTRL)) ctrl_q <= dpwm_ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_addr == ADDR_W'(A_DEAD)) dead_q <= wr_data[DT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '1;
      duty_q <= '0;
    end else if (wr_en) begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (wr_addr == ADDR_W'(gen_addr(ch, OFF_PER_LO)))
          per_q[ch][DATA_W-1:0] <= wr_data;
        if (wr_addr == ADDR_W'(gen_addr(ch, OFF_PER_HI)))
          per_q[ch][CNT_W-1:DATA_W] <= wr_data[HI_W-1:0];
        if (wr_addr == ADDR_W'(gen_addr(ch, OFF_DUTY_LO)))
          duty_q[ch][DATA_W-1:0] <= wr_data;
        if (wr_addr == ADDR_W'(gen_addr(ch, OFF_DUTY_HI)))
          duty_q[ch][CNT_W-1:DATA_W] <= wr_data[HI_W-1:0];
      end
    end
  end

endmodule

// File: rtl/dpwm_gen.sv
module dpwm_gen
  import dpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_sel,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  output logic             pwm,
  output logic             tick,
  output logic             wrap,
  output logic [CNT_W-1:0] cnt
);

  localparam int DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
  localparam int PRE_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_end;
  logic [CNT_W-1:0] per_sh;
  logic [CNT_W-1:0] duty_sh;

  function automatic logic below_duty(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] d);
    return c < d;
  endfunction

  assign pre_end = PRE_W'(pre_last(pre_sel, DIV_LO, DIV_HI));
  assign tick    = run && (pre_q == pre_end);
  assign wrap    = tick && (cnt == per_sh);
  assign pwm     = run && below_duty(cnt, duty_sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (!run)   pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (wrap)   cnt <= '0;
    else if (tick)   cnt <= cnt + CNT_W'(1);
  end

  // shadows follow the live values while stopped, and reload only at a wrap while running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh  <= '1;
      duty_sh <= '0;
    end else if (!run || wrap) begin
      per_sh  <= period;
      duty_sh <= duty;
    end
  end

endmodule

// File: rtl/dpwm_deadtime.sv
module dpwm_deadtime #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            raw,
  input  logic [DT_W-1:0] dt,
  output logic            out
);

  logic [DT_W-1:0] hold_q;

  // saturating count of clocks the source has stayed high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hold_q <= '0;
    else if (!en || !raw)  hold_q <= '0;
    else if (hold_q < dt)  hold_q <= hold_q + DT_W'(1);
  end

  assign out = en && raw && (hold_q >= dt);

endmodule

// File: rtl/dpwm_chsel.sv
module dpwm_chsel #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            comp,
  input  logic [1:0]      gen_pwm,
  input  logic [DT_W-1:0] dead,
  output logic            pwm_hi,
  output logic            pwm_lo
);

  logic [1:0] leg_src;
  logic [1:0] leg_out;

  assign leg_src[0] = gen_pwm[0];
  assign leg_src[1] = ~gen_pwm[0];

  for (genvar leg = 0; leg < 2; leg++) begin : g_leg
    dpwm_deadtime #(.DT_W(DT_W)) dt_i (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (comp),
      .raw  (leg_src[leg]),
      .dt   (dead),
      .out  (leg_out[leg])
    );
  end

  assign pwm_hi = comp ? leg_out[0] : gen_pwm[0];
  assign pwm_lo = comp ? leg_out[1] : gen_pwm[1];

endmodule

// File: rtl/dual_pwm_deadtime.sv
module dual_pwm_deadtime
  import dpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DT_W   = 8,
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 12,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_hi,
  output logic              pwm_lo
);

  dpwm_ctrl_t                ctrl_q;
  logic [DT_W-1:0]           dead_cnt;
  logic [NCH-1:0][CNT_W-1:0] per_q;
  logic [NCH-1:0][CNT_W-1:0] duty_q;

  // named internal events for the checker
  logic                      comp_mode;
  logic [NCH-1:0]            run_bits;
  logic [NCH-1:0]            pre_bits;
  logic [NCH-1:0]            gen_pwm;
  logic [NCH-1:0]            gen_tick;
  logic [NCH-1:0]            gen_wrap;
  logic [NCH-1:0][CNT_W-1:0] gen_cnt;

  assign comp_mode = ctrl_q.comp;
  assign run_bits  = ctrl_q.run;
  assign pre_bits  = ctrl_q.pre;

  dpwm_regs #(.CNT_W(CNT_W), .DT_W(DT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .ctrl_q (ctrl_q),
    .dead_q (dead_cnt),
    .per_q  (per_q),
    .duty_q (duty_q)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_gen
    dpwm_gen #(.CNT_W(CNT_W), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) gen_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_bits[ch]),
      .pre_sel(pre_bits[ch]),
      .period (per_q[ch]),
      .duty   (duty_q[ch]),
      .pwm    (gen_pwm[ch]),
      .tick   (gen_tick[ch]),
      .wrap   (gen_wrap[ch]),
      .cnt    (gen_cnt[ch])
    );
  end

  dpwm_chsel #(.DT_W(DT_W)) chsel_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .comp   (comp_mode),
    .gen_pwm(gen_pwm),
    .dead   (dead_cnt),
    .pwm_hi (pwm_hi),
    .pwm_lo (pwm_lo)
  );

endmodule

// File: rtl/dpwm_chk.sv
module dpwm_chk #(
  parameter int CNT_W  = 16,
  parameter int DT_W   = 8,
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pwm_hi,
  input logic                  pwm_lo,
  input logic                  comp_mode,
  input logic [DT_W-1:0]       dead_cnt,
  input logic [1:0]            run_bits,
  input logic [1:0]            pre_bits,
  input logic [1:0]            gen_pwm,
  input logic [1:0]            gen_tick,
  input logic [1:0]            gen_wrap,
  input logic [1:0][CNT_W-1:0] gen_cnt
);

  // R9: never both pins high in complementary mode
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    comp_mode |-> !(pwm_hi && pwm_lo));

  // R6: independent routing
  p_indep_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !comp_mode |-> (pwm_hi == gen_pwm[0]) && (pwm_lo == gen_pwm[1]));

  // R8: a delayed rise on the high pin follows a cycle with the low pin already off
  p_dead_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_mode && $past(comp_mode) && $rose(pwm_hi) && dead_cnt != '0) |-> !$past(pwm_lo));

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [7:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          gap_q <= '0;
      else if (!run_bits[ch] || gen_tick[ch]) gap_q <= '0;
      else                                 gap_q <= gap_q + 8'd1;
    end

    // R2: spacing between counter steps
    p_prescale_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      gen_tick[ch] |-> (int'(gap_q) == (pre_bits[ch] ? DIV_HI - 1 : DIV_LO - 1)));

    // R4: stopped generator is low and its counter clears
    p_stop_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !run_bits[ch] |-> !gen_pwm[ch]);
    p_stop_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !run_bits[ch] |=> gen_cnt[ch] == '0);

    // R3: single steps between wraps, zero after a wrap
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_bits[ch] && gen_tick[ch] && !gen_wrap[ch]) |=>
        (!run_bits[ch] || gen_cnt[ch] == $past(gen_cnt[ch]) + CNT_W'(1)));
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_bits[ch] && gen_wrap[ch]) |=> gen_cnt[ch] == '0);
  end

endmodule

bind dual_pwm_deadtime dpwm_chk #(
  .CNT_W (CNT_W),
  .DT_W  (DT_W),
  .DIV_LO(DIV_LO),
  .DIV_HI(DIV_HI)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwm_hi   (pwm_hi),
  .pwm_lo   (pwm_lo),
  .comp_mode(comp_mode),
  .dead_cnt (dead_cnt),
  .run_bits (run_bits),
  .pre_bits (pre_bits),
  .gen_pwm  (gen_pwm),
  .gen_tick (gen_tick),
  .gen_wrap (gen_wrap),
  .gen_cnt  (gen_cnt)
);

// File: tb/dual_pwm_deadtime_tb_top.sv
`timescale 1ns/1ps
module dual_pwm_deadtime_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_hi, pwm_lo;

  always #5 clk = ~clk;

  dual_pwm_deadtime dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
  );

  int     n_tests = 0;
  int     n_fail  = 0;
  longint cyc     = 0;
  bit     checking = 0;
  bit     finished = 0;
  string  tag = "R1";

  // bench view of the programmed state (R10 map)
  bit     m_run[2], m_pre[2], m_comp;
  int     m_dead;
  int     m_per[2], m_duty[2];
  // per-run waveform description
  longint st[2], e_sw[2];
  int     e_per[2], e_dold[2], e_dnew[2], e_div[2];
  int     rl_h, rl_l;
  bit     g0, g1, eh, el;

  function automatic bit gen_exp(int c);
    longint k, n, f, pos;
    int d;
    if (!m_run[c]) return 1'b0;
    k   = cyc - st[c];
    n   = k / e_div[c];
    f   = n / (e_per[c] + 1);
    pos = n % (e_per[c] + 1);
    d   = (f > e_sw[c]) ? e_dnew[c] : e_dold[c];
    return pos < d;
  endfunction

  function automatic int ctl(bit r0, bit r1, bit p0, bit p1, bit cm);
    return {27'd0, cm, p1, p0, r1, r0};
  endfunction

  task automatic check(bit act, bit exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: actual %b expected %b", tag, what, cyc, act, exp);
    end
  endtask

  task automatic apply(int a, int d);
    if (a == 0) begin
      for (int c = 0; c < 2; c++) begin
        bit nr = d[c];
        if (nr && !m_run[c]) begin
          st[c]     = cyc + 1;
          e_div[c]  = d[2+c] ? 12 : 4;
          e_per[c]  = m_per[c];
          e_dold[c] = m_duty[c];
          e_dnew[c] = m_duty[c];
          e_sw[c]   = 64'h7fff_ffff_ffff;
        end
        m_run[c] = nr;
        m_pre[c] = d[2+c];
      end
      m_comp = d[4];
    end else if (a == 1) begin
      m_dead = d & 8'hff;
    end else begin
      int c   = (a - 2) / 4;
      int off = (a - 2) % 4;
      case (off)
        0: m_per[c]  = (m_per[c]  & 16'hff00) | (d & 8'hff);
        1: m_per[c]  = (m_per[c]  & 16'h00ff) | ((d & 8'hff) << 8);
        2: m_duty[c] = (m_duty[c] & 16'hff00) | (d & 8'hff);
        default: m_duty[c] = (m_duty[c] & 16'h00ff) | ((d & 8'hff) << 8);
      endcase
      if (off >= 2 && m_run[c]) begin
        longint k = cyc + 1 - st[c];
        e_sw[c]   = (k / e_div[c]) / (e_per[c] + 1);
        e_dnew[c] = m_duty[c];
      end
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d[7:0];
    @(posedge clk);
    #1 apply(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_gen(int c, int p, int d);
    wr(2 + 4*c, p & 8'hff);
    wr(3 + 4*c, (p >> 8) & 8'hff);
    wr(4 + 4*c, d & 8'hff);
    wr(5 + 4*c, (d >> 8) & 8'hff);
  endtask

  task automatic run_for(int n);
    repeat (n) @(posedge clk);
  endtask

  // continuous comparison of both pins against the cycle model (R3, R6, R7, R8, R9)
  always @(posedge clk) begin
    #2;
    if (checking && !finished) begin
      cyc++;
      g0 = gen_exp(0);
      g1 = gen_exp(1);
      if (m_comp) begin
        rl_h = g0 ? rl_h + 1 : 0;
        rl_l = g0 ? 0 : rl_l + 1;
        eh   = g0 && (rl_h >= m_dead + 1);
        el   = !g0 && (rl_l >= m_dead + 1);
      end else begin
        rl_h = 0; rl_l = 0;
        eh = g0; el = g1;
      end
      check(pwm_hi, eh, "pwm_hi");
      check(pwm_lo, el, "pwm_lo");
      if (m_comp) check(pwm_hi && pwm_lo, 1'b0, "R9 overlap");
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL R1 watchdog: actual still running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_per[0] = 65535; m_per[1] = 65535; m_duty[0] = 0; m_duty[1] = 0;
    m_dead = 0; m_comp = 0;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1";
    check(pwm_hi, 1'b0, "R1 hi in reset");
    check(pwm_lo, 1'b0, "R1 lo in reset");
    rst_n = 1'b1;
    checking = 1;
    run_for(20);

    // R2: default divide-by-4 without touching the prescale bit, then divide-by-12
    tag = "R2";
    set_gen(0, 3, 2);
    wr(0, ctl(1, 0, 0, 0, 0));
    run_for(64);
    tag = "R4";
    wr(0, ctl(0, 0, 0, 0, 0));
    run_for(10);
    tag = "R2";
    wr(0, ctl(1, 0, 1, 0, 0));
    run_for(150);
    wr(0, 0);

    // R3 corners: duty 0, duty above period, period 0
    tag = "R3";
    set_gen(0, 5, 0);  wr(0, ctl(1, 0, 0, 0, 0)); run_for(60); wr(0, 0);
    set_gen(0, 5, 6);  wr(0, ctl(1, 0, 0, 0, 0)); run_for(60); wr(0, 0);
    set_gen(0, 0, 1);  wr(0, ctl(1, 0, 0, 0, 0)); run_for(40); wr(0, 0);
    set_gen(1, 0, 0);  wr(0, ctl(0, 1, 0, 0, 0)); run_for(40); wr(0, 0);

    // R5: duty change mid-frame waits for the wrap
    tag = "R5";
    set_gen(0, 9, 3);
    wr(0, ctl(1, 0, 0, 0, 0));
    run_for(19);
    wr(4, 7);
    run_for(120);
    wr(0, 0);

    // R4: stop while high, then restart from count 0
    tag = "R4";
    set_gen(0, 9, 8);
    wr(0, ctl(1, 0, 0, 0, 0));
    run_for(10);
    wr(0, 0);
    run_for(8);
    wr(0, ctl(1, 0, 0, 0, 0));
    run_for(60);
    wr(0, 0);

    // R10: high bytes of period and duty on channel 1
    tag = "R10";
    set_gen(1, 300, 260);
    wr(0, ctl(0, 1, 0, 0, 0));
    run_for(1300);
    wr(0, 0);

    // R6: two independent waveforms
    tag = "R6";
    set_gen(0, 5, 2);
    set_gen(1, 3, 3);
    wr(0, ctl(1, 1, 0, 1, 0));
    run_for(300);
    wr(0, 0);

    // R7: complementary, no gap
    tag = "R7";
    wr(1, 0);
    set_gen(0, 7, 3);
    wr(0, ctl(1, 0, 0, 0, 1));
    run_for(200);
    wr(0, 0);

    // R8: gap of 3, then a gap longer than either pulse
    tag = "R8";
    wr(1, 3);
    wr(0, ctl(1, 0, 0, 0, 1));
    run_for(200);
    wr(0, 0);
    wr(1, 50);
    set_gen(0, 9, 5);
    wr(0, ctl(1, 0, 0, 0, 1));
    run_for(200);
    wr(0, 0);

    // random configurations in both modes (R3, R6, R7, R8, R9)
    for (int it = 0; it < 16; it++) begin
      int p0, p1, d0, d1, dt;
      bit pr0, pr1, cm;
      wr(0, 0);
      p0  = $urandom_range(0, 24);
      p1  = $urandom_range(0, 24);
      d0  = $urandom_range(0, p0 + 2);
      d1  = $urandom_range(0, p1 + 2);
      dt  = $urandom_range(0, 6);
      pr0 = 1'($urandom_range(0, 1));
      pr1 = 1'($urandom_range(0, 1));
      cm  = 1'($urandom_range(0, 1));
      tag = cm ? "R8" : "R6";
      wr(1, dt);
      set_gen(0, p0, d0);
      set_gen(1, p1, d1);
      wr(0, ctl(1, 1, pr0, pr1, cm));
      run_for($urandom_range(150, 600));
    end
    wr(0, 0);
    run_for(5);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule